// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block holds two 16-bit timer/counter channels, T0 and T1, each built from a low and a high byte that software writes one at a time. A channel either counts machine cycles or counts falling edges on its own external count pin. A machine cycle is a fixed number of system clocks (12 by default). A run bit starts and stops each channel. An optional gate makes the count also depend on a gate pin. Each channel has four count modes: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself, and a split mode that turns T0 into two independent 8-bit counters.

When a channel rolls over it raises an overflow flag, which drives an interrupt request output. The flag drops when the matching acknowledge strobe arrives, or when software writes a zero to it. All registers are written through one byte-wide write port. Their contents are read back through a combinational read port.

Top module: `dual_tmr_top`

## Requirements
- R1: Register map, by address: 0 is the mode byte, with T0 in bits 3:0 and T1 in bits 7:4. Each nibble holds, from its most significant bit: gate, external-count select, mode[1:0]. Address 1 is the run/flag byte: bit0 T0 run, bit1 T0 flag, bit2 T1 run, bit3 T1 flag. Addresses 2 and 3 are the T0 low and high bytes; 4 and 5 are the T1 low and high bytes. After reset, every register and both bits of `ovf_o` read zero.
- R2: With the external-count select cleared, a running channel advances by exactly one per machine cycle of 12 clocks.
- R3: With the external-count select set, the pin is sampled once per machine cycle. The count advances only when a high sample is followed by a low sample, so a pin that toggles every clock, seen at the same phase each time, never counts.
- R4: With the gate bit set, a channel counts only while its gate pin is high. With the gate bit cleared, the run bit alone controls it.
- R5: Mode 1 (16-bit) rolls over from FFFF to 0000 and sets the channel flag.
- R6: Mode 0 (13-bit): the low 5 bits of the low byte act as a prescaler under the high byte, and low-byte bits 7:5 are kept. A carry out of high byte FF sets the flag.
- R7: Mode 2: the low byte counts. When it passes FF it is reloaded from the high byte and the flag is set.
- R8: With T0 in mode 3, the T0 low byte counts under T0 run and sets T0's flag. The T0 high byte counts machine cycles under T1 run and sets T1's flag.
- R9: While T0 is in mode 3, T1 counts whatever its run and gate settings are, and its own rollover sets no flag.
- R10: An acknowledge strobe clears its flag on the next clock. Writing the run/flag byte clears each flag written as 0 and keeps each flag written as 1.
- R11: A write to a count byte wins over an increment in the same cycle.
- R12: T1 placed in mode 3 holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_cnt_i | input | 2 | External count pins, bit0 T0, bit1 T1 |
| gate_pin_i | input | 2 | Gate pins, bit0 T0, bit1 T1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Combinational read data |
| ack_i | input | 2 | Interrupt acknowledge strobes, bit0 T0, bit1 T1 |
| ovf_o | output | 2 | Overflow flags, bit0 T0, bit1 T1 |

## Verification
The clock edge that accepts a register write updates that register, and the read port shows the new value on the same cycle. A count byte changes on a machine-cycle clock edge. A flag changes one clock after the overflowing increment or the acknowledge. Each count window in the bench opens with one mode write and closes with another, exactly 12·K clock edges later, so K machine-cycle ticks fall inside it whatever the phase of the divider. The write-priority test first finds a tick edge by watching the count, then aligns its write to a later tick. All outputs are sampled at the falling clock edge.

// File: rtl/tmr_pkg.sv
// Shared types and register addresses for the dual timer/counter unit.
package tmr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        M_13BIT   = 2'd0,
        M_16BIT   = 2'd1,
        M_RELOAD8 = 2'd2,
        M_SPLIT   = 2'd3
    } tmode_e;

    typedef struct packed {
        logic   gate;
        logic   ext;
        tmode_e mode;
    } chan_cfg_t;

    localparam logic [2:0] A_MODE = 3'd0;
    localparam logic [2:0] A_RUNF = 3'd1;
    localparam logic [2:0] A_T0L  = 3'd2;
    localparam logic [2:0] A_T0H  = 3'd3;
    localparam logic [2:0] A_T1L  = 3'd4;
    localparam logic [2:0] A_T1H  = 3'd5;
endpackage

// File: rtl/tmr_tick_gen.sv
// Machine-cycle tick generator.
// Emits a one-clock pulse once every DIV clocks. The first pulse comes
// DIV clocks after reset. Assumes DIV >= 2.
module tmr_tick_gen #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == CW'(DIV - 1));

    // Wrap-around divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tmr_edge_sense.sv
// Falling-edge detector, sampled at the machine-cycle rate.
// Keeps the pin level seen at the previous tick. Reports an event on a
// tick that sees low right after a tick that saw high.
// Assumes pin_i is already synchronous to clk.
module tmr_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pin_i,
    output logic fall_o
);
    logic prev_q;

    assign fall_o = tick_i & prev_q & ~pin_i;

    // Record the pin level at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_q <= 1'b0;
        else if (tick_i) prev_q <= pin_i;
    end
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: a low byte and a high byte with four count modes.
// inc_i advances the main counter. inc_hi_i advances the high byte, and
// only in split mode. A byte write beats an increment of that byte.
// An overflow pulse is dropped in any cycle where a write touches the
// counter that overflowed.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int PRE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmode_e            mode_i,
    input  logic              inc_i,
    input  logic              inc_hi_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              ovf_o,
    output logic              ovf_hi_o
);
    localparam logic [BYTE_W-1:0] BMAX = '1;

    logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
    logic              ovf_raw, ovf_hi_raw;

    // Next-state count logic for the selected mode.
    always_comb begin
        lo_n       = lo_q;
        hi_n       = hi_q;
        ovf_raw    = 1'b0;
        ovf_hi_raw = 1'b0;
        unique case (mode_i)
            M_13BIT: if (inc_i) begin
                if (lo_q[PRE_W-1:0] == '1) begin
                    lo_n[PRE_W-1:0] = '0;
                    hi_n            = hi_q + 1'b1;
                    ovf_raw         = (hi_q == BMAX);
                end else begin
                    lo_n[PRE_W-1:0] = PRE_W'(lo_q[PRE_W-1:0] + 1'b1);
                end
            end
            M_16BIT: if (inc_i) begin
                {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
                ovf_raw      = ({hi_q, lo_q} == {BMAX, BMAX});
            end
            M_RELOAD8: if (inc_i) begin
                if (lo_q == BMAX) begin
                    lo_n    = hi_q;
                    ovf_raw = 1'b1;
                end else begin
                    lo_n = lo_q + 1'b1;
                end
            end
            M_SPLIT: begin
                if (inc_i) begin
                    lo_n    = lo_q + 1'b1;
                    ovf_raw = (lo_q == BMAX);
                end
                if (inc_hi_i) begin
                    hi_n       = hi_q + 1'b1;
                    ovf_hi_raw = (hi_q == BMAX);
                end
            end
            default: ;
        endcase
        if (wr_lo_i) lo_n = wdata_i;
        if (wr_hi_i) hi_n = wdata_i;
    end

    // Suppress overflow when a write overrides the counter that wrapped.
    always_comb begin
        if (mode_i == M_SPLIT) begin
            ovf_o    = ovf_raw & ~wr_lo_i;
            ovf_hi_o = ovf_hi_raw & ~wr_hi_i;
        end else begin
            ovf_o    = ovf_raw & ~(wr_lo_i | wr_hi_i);
            ovf_hi_o = 1'b0;
        end
    end

    // Count byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;
endmodule

// File: rtl/dual_tmr_top.sv
// Dual timer/counter unit: two channels, a mode byte, a run/flag byte.
// Assumes all pins are synchronous to clk and that writes are one byte
// per cycle. T0 split mode takes over T1's run bit and flag for the T0
// high byte. T1 then counts freely.
module dual_tmr_top
    import tmr_pkg::*;
#(
    parameter int MC_DIV = 12,
    parameter int PRE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ext_cnt_i,
    input  logic [1:0]        gate_pin_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [2:0]        rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o,
    input  logic [1:0]        ack_i,
    output logic [1:0]        ovf_o
);
    localparam int NCH = 2;

    logic              tick;
    logic [BYTE_W-1:0] mode_q;
    logic [NCH-1:0]    run_q, flag_q, flag_n;
    chan_cfg_t         cfg    [NCH];
    logic [NCH-1:0]    fall, src, inc, inc_hi, wr_lo, wr_hi;
    logic [NCH-1:0]    ovf_main, ovf_split, set;
    logic [BYTE_W-1:0] lo     [NCH];
    logic [BYTE_W-1:0] hi     [NCH];
    logic [15:0]       t0_cnt, t1_cnt;
    logic              t0_split, t1_hold, wr_runf;

    tmr_tick_gen #(.DIV(MC_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    assign cfg[0]   = chan_cfg_t'(mode_q[3:0]);
    assign cfg[1]   = chan_cfg_t'(mode_q[7:4]);
    assign t0_split = (cfg[0].mode == M_SPLIT);
    assign t1_hold  = (cfg[1].mode == M_SPLIT);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_edge_sense u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .tick_i(tick),
            .pin_i (ext_cnt_i[i]),
            .fall_o(fall[i])
        );

        assign src[i]   = cfg[i].ext ? fall[i] : tick;
        assign wr_lo[i] = wr_en_i && (wr_addr_i == A_T0L + 3'(2 * i));
        assign wr_hi[i] = wr_en_i && (wr_addr_i == A_T0H + 3'(2 * i));

        tmr_channel #(.PRE_W(PRE_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_i  (cfg[i].mode),
            .inc_i   (inc[i]),
            .inc_hi_i(inc_hi[i]),
            .wr_lo_i (wr_lo[i]),
            .wr_hi_i (wr_hi[i]),
            .wdata_i (wr_data_i),
            .lo_o    (lo[i]),
            .hi_o    (hi[i]),
            .ovf_o   (ovf_main[i]),
            .ovf_hi_o(ovf_split[i])
        );
    end

    // Count enables: run and gate control, with T1 freed during T0 split.
    always_comb begin
        inc[0]    = run_q[0] & (~cfg[0].gate | gate_pin_i[0]) & src[0];
        inc_hi[0] = t0_split & run_q[1] & tick;
        inc_hi[1] = 1'b0;
        if (t1_hold)       inc[1] = 1'b0;
        else if (t0_split) inc[1] = src[1];
        else               inc[1] = run_q[1] & (~cfg[1].gate | gate_pin_i[1]) & src[1];
    end

    // Flag set sources: T1 flag follows the T0 high byte in split mode.
    assign set[0] = ovf_main[0];
    assign set[1] = t0_split ? ovf_split[0] : (ovf_main[1] | ovf_split[1]);

    assign wr_runf = wr_en_i && (wr_addr_i == A_RUNF);

    // Flag next state: software clear, then acknowledge, then hardware set.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            flag_n[i] = flag_q[i];
            if (wr_runf)  flag_n[i] = flag_q[i] & wr_data_i[2*i+1];
            if (ack_i[i]) flag_n[i] = 1'b0;
            if (set[i])   flag_n[i] = 1'b1;
        end
    end

    // Control registers: mode byte, run bits and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (wr_en_i && wr_addr_i == A_MODE) mode_q <= wr_data_i;
            if (wr_runf) run_q <= {wr_data_i[2], wr_data_i[0]};
            flag_q <= flag_n;
        end
    end

    assign t0_cnt = {hi[0], lo[0]};
    assign t1_cnt = {hi[1], lo[1]};
    assign ovf_o  = flag_q;

    // Combinational register readback.
    always_comb begin
        unique case (rd_addr_i)
            A_MODE:  rd_data_o = mode_q;
            A_RUNF:  rd_data_o = {4'b0, flag_q[1], run_q[1], flag_q[0], run_q[0]};
            A_T0L:   rd_data_o = t0_cnt[7:0];
            A_T0H:   rd_data_o = t0_cnt[15:8];
            A_T1L:   rd_data_o = t1_cnt[7:0];
            A_T1H:   rd_data_o = t1_cnt[15:8];
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/dual_tmr_chk.sv
// Assertion checker for dual_tmr_top, attached by bind.
module dual_tmr_chk
    import tmr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        wr_en_i,
    input logic [2:0]  wr_addr_i,
    input logic [7:0]  wr_data_i,
    input logic [1:0]  ack_i,
    input logic [1:0]  ovf_o,
    input logic [1:0]  set,
    input logic [7:0]  mode_q,
    input logic [15:0] t0_cnt,
    input logic [15:0] t1_cnt
);
    logic wr_t0, wr_t1;
    assign wr_t0 = wr_en_i && (wr_addr_i == A_T0L || wr_addr_i == A_T0H);
    assign wr_t1 = wr_en_i && (wr_addr_i == A_T1L || wr_addr_i == A_T1H);

    // R2: in timer or counter use, T0 moves only on a machine-cycle tick
    a_r2_count_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_t0) |=> $stable(t0_cnt));

    // R11: a low-byte write lands even if an increment was due
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_T0L) |=> (t0_cnt[7:0] == $past(wr_data_i)));

    // R10: acknowledge without a new overflow clears the flag
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i[0] && !set[0]) |=> !ovf_o[0]);

    // R5: a flag can only rise on a machine-cycle tick
    a_r5_flag_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o[0]) |-> $past(tick));

    // R12: T1 in mode 3 holds its count
    a_r12_t1_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[5:4] == 2'd3 && !wr_t1) |=> $stable(t1_cnt));
endmodule

bind dual_tmr_top dual_tmr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .ack_i    (ack_i),
    .ovf_o    (ovf_o),
    .set      (set),
    .mode_q   (mode_q),
    .t0_cnt   (t0_cnt),
    .t1_cnt   (t1_cnt)
);

// File: tb/dual_tmr_top_tb_top.sv
`timescale 1ns/1ps
module dual_tmr_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_cnt = 2'b00;
    logic [1:0] gate_pin = 2'b00;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] ack = 2'b00;
    logic [1:0] ovf;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    localparam logic [7:0] NEUTRAL = 8'h44;

    always #10 clk = ~clk;

    dual_tmr_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_cnt_i (ext_cnt),
        .gate_pin_i(gate_pin),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .ack_i     (ack),
        .ovf_o     (ovf)
    );

    typedef struct packed {
        logic [7:0] mode, run, t0l, t0h, t1l, t1h, k;
        logic [7:0] e0l, e0h, e1l, e1h;
        logic [1:0] eovf;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'd5, 8'h05, 8'h00, 8'h00, 8'h00, 2'b00}, // R2
        '{8'h01, 8'h01, 8'hFE, 8'hFF, 8'h00, 8'h00, 8'd3, 8'h01, 8'h00, 8'h00, 8'h00, 2'b01}, // R5
        '{8'h00, 8'h01, 8'hFE, 8'hFF, 8'h00, 8'h00, 8'd2, 8'hE0, 8'h00, 8'h00, 8'h00, 2'b01}, // R6 wrap
        '{8'h00, 8'h01, 8'hBF, 8'h10, 8'h00, 8'h00, 8'd1, 8'hA0, 8'h11, 8'h00, 8'h00, 2'b00}, // R6 carry
        '{8'h02, 8'h01, 8'hFE, 8'h80, 8'h00, 8'h00, 8'd3, 8'h81, 8'h80, 8'h00, 8'h00, 2'b01}, // R7
        '{8'h13, 8'h05, 8'hFF, 8'hFE, 8'h10, 8'h00, 8'd2, 8'h01, 8'h00, 8'h12, 8'h00, 2'b11}, // R8
        '{8'h13, 8'h01, 8'h00, 8'h40, 8'hFF, 8'hFF, 8'd2, 8'h02, 8'h40, 8'h01, 8'h00, 2'b00}, // R9
        '{8'h30, 8'h04, 8'h00, 8'h00, 8'h34, 8'h12, 8'd3, 8'h00, 8'h00, 8'h34, 8'h12, 2'b00}, // R12
        '{8'h11, 8'h05, 8'h00, 8'h00, 8'hF0, 8'hFF, 8'd4, 8'h04, 8'h00, 8'hF4, 8'hFF, 2'b00}  // R2 both
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        logic [7:0] d;
        v = VECS[i];
        wr(3'd1, 8'h00);
        wr(3'd0, NEUTRAL);
        wr(3'd2, v.t0l); wr(3'd3, v.t0h);
        wr(3'd4, v.t1l); wr(3'd5, v.t1h);
        wr(3'd1, v.run);
        wr(3'd0, v.mode);           // window opens
        idle(12 * int'(v.k) - 1);
        wr(3'd0, NEUTRAL);          // window closes 12*K edges later
        rd(3'd2, d); check($sformatf("vec%0d T0 low", i), d, v.e0l);
        rd(3'd3, d); check($sformatf("vec%0d T0 high", i), d, v.e0h);
        rd(3'd4, d); check($sformatf("vec%0d T1 low", i), d, v.e1l);
        rd(3'd5, d); check($sformatf("vec%0d T1 high", i), d, v.e1h);
        check($sformatf("vec%0d flags", i), {6'b0, ovf}, {6'b0, v.eovf});
    endtask

    initial begin
        logic [7:0] d;
        bit found;
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            check($sformatf("R1 reset addr %0d", a), d, 8'h00);
        end
        check("R1 reset flags", {6'b0, ovf}, 8'h00);
        rst_n = 1'b1;
        idle(1);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R3: slow pin, three falling edges
        wr(3'd1, 8'h00); wr(3'd0, NEUTRAL);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd1, 8'h01);
        idle(24);
        wr(3'd0, 8'h05);
        for (int j = 0; j < 3; j++) begin
            ext_cnt[0] = 1'b1; idle(48);
            ext_cnt[0] = 1'b0; idle(48);
        end
        wr(3'd1, 8'h00);
        rd(3'd2, d); check("R3 edge count", d, 8'h03);
        // R3: toggling every clock is never seen as an edge
        wr(3'd1, 8'h01);
        for (int j = 0; j < 240; j++) begin
            ext_cnt[0] = ~ext_cnt[0]; idle(1);
        end
        wr(3'd1, 8'h00);
        ext_cnt[0] = 1'b0;
        rd(3'd2, d); check("R3 fast toggle ignored", d, 8'h03);

        // R4: gate pin low blocks, high allows
        wr(3'd0, NEUTRAL); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd1, 8'h01);
        gate_pin[0] = 1'b0;
        wr(3'd0, 8'h09); idle(35); wr(3'd0, NEUTRAL);
        rd(3'd2, d); check("R4 gate low", d, 8'h00);
        gate_pin[0] = 1'b1;
        wr(3'd0, 8'h09); idle(35); wr(3'd0, NEUTRAL);
        rd(3'd2, d); check("R4 gate high", d, 8'h03);
        gate_pin[0] = 1'b0;

        // R10: acknowledge and software clear
        run_vec(1);
        ack = 2'b01; idle(1); ack = 2'b00;
        check("R10 ack T0", {6'b0, ovf}, 8'h00);
        run_vec(5);
        wr(3'd1, 8'h08);
        check("R10 write-zero clears T0 only", {6'b0, ovf}, 8'h02);
        ack = 2'b10; idle(1); ack = 2'b00;
        check("R10 ack T1", {6'b0, ovf}, 8'h00);

        // R11: write on a tick edge wins
        wr(3'd1, 8'h00); wr(3'd0, 8'h01);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd1, 8'h01);
        found = 1'b0;
        for (int j = 0; j < 40 && !found; j++) begin
            rd(3'd2, d);
            if (d != 8'h00) found = 1'b1;
            else idle(1);
        end
        idle(11);
        wr(3'd2, 8'h80);
        rd(3'd2, d); check("R11 write beats increment", d, 8'h80);
        wr(3'd1, 8'h00);
        rd(3'd3, d); check("R11 high byte untouched", d, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule